// File: doc/BRIEF.md
# Serial EEPROM Boot Configuration Loader

After power-on reset this block fetches the hub's identity and power-management setting from an external serial EEPROM. It makes its own serial clock by dividing the system clock, and it holds the chip select high for the whole transfer. On a single bidirectional data pin it sends a start bit, a read opcode and an all-zero word address. It then releases the pin, discards the dummy bit the memory returns, and shifts in 48 data bits. The memory increments its own address, so those 48 bits are three consecutive 16-bit words. When the transfer ends, every pin the block owns goes to high impedance for the rest of the session, so other logic can use the memory.

The loaded result is a ganged-power flag, a vendor ID and a product ID. It is presented on plain outputs and qualified by `done`. Logic that depends on it waits for `done`, which stays high until the next reset. A strap input turns the interface off. In that case the serial clock never toggles, the IDs take built-in defaults, and the data pin is sampled as a static ganged/per-port select.

Top module: `cfgrom_loader`

## Requirements
- R1: The serial clock changes level only once every HALF_DIV system cycles, so one full serial period is 2*HALF_DIV cycles. It is low when idle, and the first edge after reset is a rising one.
- R2: With the strap low, the block drives 3+ADDR_W command bits, most significant first: a start bit 1, the read opcode 1 then 0, and ADDR_W zero address bits. Each bit is set up while the clock is low and held while it is high.
- R3: After the rising edge that transfers the last address bit, the block stops driving the data pin, and it does not drive it again.
- R4: Incoming bits are sampled on falling serial-clock edges. The first bit after the command is a dummy and is discarded. The next 48 bits are taken MSB first as word 0, word 1, word 2.
- R5: Exactly 3+ADDR_W+48 rising serial-clock edges occur per transfer, and none after it.
- R6: `ganged` is bit 14 of word 0, with the other bits of word 0 ignored. `vendor_id` is word 1 and `product_id` is word 2, each with its high byte in bits 15..8.
- R7: After the last data bit, the clock and data output enables are low and stay low until reset.
- R8: `csel_o` is high from the start of the transfer until the last data bit is taken, and low otherwise.
- R9: With the strap high, there are no clock edges and no output enables. The IDs equal DEF_VID and DEF_PID, and `ganged` follows the level on the data pin.
- R10: Until `done` rises, `vendor_id`, `product_id` and `ganged` read zero.
- R11: Once high, `done` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; a load starts after its release |
| strap_off | input | 1 | High turns the EEPROM interface off; static |
| sclk_o | output | 1 | Serial clock to the EEPROM |
| sclk_oe | output | 1 | Output enable of the serial clock pin |
| sdata_i | input | 1 | Level seen on the shared data pin |
| sdata_o | output | 1 | Value driven onto the data pin |
| sdata_oe | output | 1 | Output enable of the data pin |
| csel_o | output | 1 | EEPROM chip select, high during the transfer |
| done | output | 1 | Configuration valid |
| ganged | output | 1 | Ganged power management selected |
| vendor_id | output | 16 | Loaded or default vendor ID |
| product_id | output | 16 | Loaded or default product ID |

## Verification
A behavioural memory in the bench answers on rising clock edges and drives a dummy 0 straight after the address. A loader that did not discard the dummy would show every ID shifted by one bit. Several word patterns are swept, including set bits in word 0 outside bit 14, which would corrupt `ganged` if it were taken from the wrong position. The bench counts rising edges and measures the spacing between them, which exposes an extra 49th data clock, a wrong divider, or a clock that keeps running after the load. It watches the data-pin enable on both sides of the handover, so a late release or a re-drive shows up. Both strap levels are run with the interface off, which catches a loader that toggles the clock there or latches defaults into the wrong output.

// File: rtl/cfl_pkg.sv
package cfl_pkg;
  localparam int WORD_W    = 16;
  localparam int N_WORDS   = 3;
  localparam int DATA_BITS = WORD_W * N_WORDS;
  localparam int PRE_BITS  = 3;            // start bit plus two opcode bits
  localparam logic [PRE_BITS-1:0] READ_PRE = 3'b110;
  localparam int GANG_POS  = 2 * WORD_W + 14; // word 0 bit 14 in the 48-bit stream

  typedef enum logic [1:0] {PH_BOOT, PH_XFER, PH_DONE} phase_e;

  typedef struct packed {
    logic              gang;
    logic [WORD_W-1:0] vid;
    logic [WORD_W-1:0] pid;
  } cfg_t;
endpackage

// File: rtl/cfl_tick.sv
module cfl_tick #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (!run || cnt == LAST) cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);

  generate
    if (HALF_DIV > 1) begin : g_gap
      // R1
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/cfl_seq.sv
module cfl_seq
  import cfl_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_off,
  input  logic tick,
  input  logic sdata_i,
  output logic run,
  output logic sclk,
  output logic sclk_oe,
  output logic sd_o,
  output logic sd_oe,
  output logic csel,
  output logic load_done,
  output logic bypass,
  output cfg_t cfg
);
  localparam int NCMD  = PRE_BITS + ADDR_W;
  localparam int NRISE = NCMD + DATA_BITS;
  localparam int CNT_W = $clog2(NRISE + 1);
  localparam logic [NCMD-1:0] CMD = {READ_PRE, {ADDR_W{1'b0}}};

  phase_e               ph;
  logic [CNT_W-1:0]     rise;
  logic [NCMD-1:0]      cmd_sh;
  logic [DATA_BITS-2:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_BOOT; rise <= '0; cmd_sh <= '0; shreg <= '0;
      sclk <= 1'b0; sclk_oe <= 1'b0; sd_o <= 1'b0; sd_oe <= 1'b0;
      csel <= 1'b0; load_done <= 1'b0; bypass <= 1'b0;
    end else begin
      unique case (ph)
        PH_BOOT: begin
          if (strap_off) begin
            bypass <= 1'b1; load_done <= 1'b1; ph <= PH_DONE;
          end else begin
            csel <= 1'b1; sclk_oe <= 1'b1; sd_oe <= 1'b1;
            cmd_sh <= CMD; sd_o <= CMD[NCMD-1]; ph <= PH_XFER;
          end
        end
        PH_XFER: begin
          if (tick) begin
            if (!sclk) begin
              sclk <= 1'b1;
              rise <= rise + 1'b1;
              if (rise == CNT_W'(NCMD - 1)) sd_oe <= 1'b0;
            end else begin
              sclk <= 1'b0;
              if (rise < CNT_W'(NCMD)) begin
                sd_o   <= cmd_sh[NCMD-2];
                cmd_sh <= {cmd_sh[NCMD-2:0], 1'b0};
              end else if (rise > CNT_W'(NCMD)) begin
                shreg <= {shreg[DATA_BITS-3:0], sdata_i};
              end
              if (rise == CNT_W'(NRISE)) begin
                csel <= 1'b0; sclk_oe <= 1'b0; sd_oe <= 1'b0;
                sd_o <= 1'b0; load_done <= 1'b1; ph <= PH_DONE;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign run      = (ph == PH_XFER);
  assign cfg.gang = shreg[GANG_POS];
  assign cfg.vid  = shreg[2*WORD_W-1:WORD_W];
  assign cfg.pid  = shreg[WORD_W-1:0];

  // R1
  sclk_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != $past(sclk)) |-> $past(tick));
  // R2
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_oe && sclk && $past(sclk)) |-> $stable(sd_o));
  // R5
  rise_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise <= CNT_W'(NRISE));
  // R7
  pins_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> (!sclk_oe && !sd_oe && !sclk));
  // R8
  csel_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_oe || sclk) |-> csel);
  // R11
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> load_done);
endmodule

// File: rtl/cfl_fields.sv
module cfl_fields
  import cfl_pkg::*;
#(
  parameter logic [WORD_W-1:0] DEF_VID = 16'h0451,
  parameter logic [WORD_W-1:0] DEF_PID = 16'h2077
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_done,
  input  logic              bypass,
  input  logic              pin,
  input  cfg_t              cfg,
  output logic              done,
  output logic              ganged,
  output logic [WORD_W-1:0] vid,
  output logic [WORD_W-1:0] pid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0; ganged <= 1'b0; vid <= '0; pid <= '0;
    end else begin
      done <= load_done;
      if (load_done) begin
        if (bypass) begin
          ganged <= pin; vid <= DEF_VID; pid <= DEF_PID;
        end else begin
          ganged <= cfg.gang; vid <= cfg.vid; pid <= cfg.pid;
        end
      end
    end
  end

  // R10
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (vid == '0 && pid == '0 && !ganged));
endmodule

// File: rtl/cfgrom_loader.sv
module cfgrom_loader
  import cfl_pkg::*;
#(
  parameter int          ADDR_W   = 6,
  parameter int          HALF_DIV = 4,
  parameter logic [15:0] DEF_VID  = 16'h0451,
  parameter logic [15:0] DEF_PID  = 16'h2077
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strap_off,
  output logic        sclk_o,
  output logic        sclk_oe,
  input  logic        sdata_i,
  output logic        sdata_o,
  output logic        sdata_oe,
  output logic        csel_o,
  output logic        done,
  output logic        ganged,
  output logic [15:0] vendor_id,
  output logic [15:0] product_id
);
  logic run, tick, load_done, bypass;
  cfg_t cfg;

  cfl_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick));

  cfl_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .strap_off(strap_off), .tick(tick),
    .sdata_i(sdata_i), .run(run), .sclk(sclk_o), .sclk_oe(sclk_oe),
    .sd_o(sdata_o), .sd_oe(sdata_oe), .csel(csel_o),
    .load_done(load_done), .bypass(bypass), .cfg(cfg));

  cfl_fields #(.DEF_VID(DEF_VID), .DEF_PID(DEF_PID)) u_fields (
    .clk(clk), .rst_n(rst_n), .load_done(load_done), .bypass(bypass),
    .pin(sdata_i), .cfg(cfg), .done(done), .ganged(ganged),
    .vid(vendor_id), .pid(product_id));

  // R9
  strap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strap_off |-> (!sclk_oe && !sdata_oe && !csel_o));
endmodule

// File: tb/cfgrom_loader_bench.sv
module cfgrom_loader_bench;
  localparam int ADDR_W = 6;
  localparam int HALF   = 3;
  localparam int NCMD   = 3 + ADDR_W;
  localparam int NRISE  = NCMD + 48;
  localparam logic [15:0] DVID = 16'hBEEF;
  localparam logic [15:0] DPID = 16'h1234;

  logic clk = 1'b0, rst_n = 1'b0, strap_off = 1'b0, pin_level = 1'b0;
  logic sclk_o, sclk_oe, sdata_i, sdata_o, sdata_oe, csel_o, done, ganged;
  logic [15:0] vendor_id, product_id;

  int checks = 0, errors = 0, cycles = 0;
  int redge = 0, bad_drive = 0, bad_per = 0;
  longint last_t = 0;
  logic [NCMD-1:0] cmd_rx = '0;
  logic [47:0] data48 = '0;
  logic ee_drive = 1'b0, ee_bit = 1'b0;

  always #2 clk = ~clk;

  assign sdata_i = sdata_oe ? sdata_o : (ee_drive ? ee_bit : pin_level);

  cfgrom_loader #(.ADDR_W(ADDR_W), .HALF_DIV(HALF), .DEF_VID(DVID), .DEF_PID(DPID))
    u_cfgrom_loader (
      .clk(clk), .rst_n(rst_n), .strap_off(strap_off), .sclk_o(sclk_o),
      .sclk_oe(sclk_oe), .sdata_i(sdata_i), .sdata_o(sdata_o),
      .sdata_oe(sdata_oe), .csel_o(csel_o), .done(done), .ganged(ganged),
      .vendor_id(vendor_id), .product_id(product_id));

  // memory model: launches data on rising serial clock edges
  always @(posedge sclk_o) begin
    redge = redge + 1;
    if (redge > 1 && ($time - last_t) != longint'(4 * 2 * HALF)) bad_per = bad_per + 1;
    last_t = $time;
    if (!csel_o) bad_drive = bad_drive + 1;
    if (redge <= NCMD) begin
      cmd_rx = {cmd_rx[NCMD-2:0], sdata_o};
      if (redge < NCMD && !sdata_oe) bad_drive = bad_drive + 1;
      if (redge == NCMD) begin ee_drive = 1'b1; ee_bit = 1'b0; end
    end else begin
      if (redge > NCMD + 1 && sdata_oe) bad_drive = bad_drive + 1;
      if (redge - NCMD - 1 < 48) ee_bit = data48[47 - (redge - NCMD - 1)];
      else ee_bit = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic start(input logic strap, input logic pin, input logic [47:0] d);
    @(negedge clk);
    rst_n = 1'b0; strap_off = strap; pin_level = pin; data48 = d;
    redge = 0; bad_drive = 0; bad_per = 0; ee_drive = 1'b0; cmd_rx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done == 1'b1, "R11 done timeout", done, 1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        finish_run();
      end
    end
  end

  initial begin
    chk(done == 1'b0 && sclk_oe == 1'b0, "R10 reset state", done, 0);
    for (int p = 0; p < 6; p++) begin
      logic [15:0] w0, w1, w2;
      w0 = (p[0] ? 16'h4000 : 16'h0000) | ((p >= 4) ? 16'hB3FF : 16'h0000);
      w1 = 16'((p * 16'h1111) ^ 16'hC3A5);
      w2 = 16'(~w1 + 16'(p));
      start(1'b0, ~p[0], {w0, w1, w2});
      @(negedge clk);
      chk(done == 1'b0 && vendor_id == 16'h0 && product_id == 16'h0 && !ganged,
          "R10 outputs held", vendor_id, 0);
      repeat (10) @(negedge clk);
      chk(csel_o == 1'b1, "R8 csel during", csel_o, 1);
      wait_done();
      chk(cmd_rx == {3'b110, {ADDR_W{1'b0}}}, "R2 command bits", cmd_rx, {3'b110, {ADDR_W{1'b0}}});
      chk(bad_drive == 0, "R3 handover", bad_drive, 0);
      chk(bad_per == 0, "R1 serial period", bad_per, 0);
      chk(redge == NRISE, "R5 edge count", redge, NRISE);
      chk(vendor_id == w1, "R4 R6 vendor id", vendor_id, w1);
      chk(product_id == w2, "R4 R6 product id", product_id, w2);
      chk(ganged == w0[14], "R6 ganged bit", ganged, w0[14]);
      chk(!sclk_oe && !sdata_oe && !csel_o, "R7 R8 pins idle", {sclk_oe, sdata_oe, csel_o}, 0);
      repeat (40) @(negedge clk);
      chk(redge == NRISE && done, "R5 R11 quiet after", redge, NRISE);
      chk(!sclk_oe && !sdata_oe, "R7 stays released", {sclk_oe, sdata_oe}, 0);
    end
    for (int g = 0; g < 2; g++) begin
      start(1'b1, g[0], 48'h0);
      repeat (5) @(negedge clk);
      chk(done == 1'b1, "R9 done in bypass", done, 1);
      chk(vendor_id == DVID && product_id == DPID, "R9 default ids", vendor_id, DVID);
      chk(ganged == g[0], "R9 ganged strap", ganged, g[0]);
      repeat (30) @(negedge clk);
      chk(redge == 0 && !sclk_oe && !sdata_oe && !csel_o, "R9 no clocking", redge, 0);
    end
    finish_run();
  end
endmodule